// File: doc/BRIEF.md
# Iterative complex-binary adder

This block adds two fixed-width words written in the binary positional system whose radix is the complex number −1+j. In that system a single bit string holds both the real and the imaginary part, and the single-digit sums are 0+0=0, 0+1=1, 1+0=1 and 1+1=1100. So two ones in the same column clear that column and the one above it, and put a one in each of the two columns above those. The sum is found by repetition. The datapath keeps three addend words and compresses them to one partial sum and one majority (carry) word. The carry word goes back in twice, shifted up by two places and by three places. This repeats until the carry word is zero.

The word width is fixed, so every carry bit that would move above the most significant digit is discarded and the overflow flag is raised. Because of this, the endless carry chain of the zero rule (11 + 111, that is j + (−j)) stops after a few rounds with a zero sum. The result equals the true Gaussian-integer sum reduced modulo (−1+j)^WIDTH. A caller pulses `start` with both operands present, waits for `done`, and reads `sum` and `overflow`. Both stay stable until the next accepted start.

Top module: `cbin_adder`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are 0 and `sum` is all zeros.
- R2: A `start` seen while `busy` is 0 captures `op_a` and `op_b`, and `busy` is 1 after that edge. A `start` seen while `busy` is 1 is ignored, and the result in progress still belongs to the operands captured first.
- R3: When `done` rises, `sum` is the digit string whose value, reading bit k as weight (−1+j)^k, equals value(op_a)+value(op_b) modulo (−1+j)^WIDTH.
- R4: If `op_a & op_b` is zero, no carry is produced, so `sum` equals `op_a | op_b` and `overflow` is 0.
- R5: Two ones in bit 0 give bits 3 and 2 set and bits 1 and 0 clear, so 1 + 1 gives `sum` = 0b1100 with `overflow` 0.
- R6: Zero rule: 0b11 + 0b111 gives `sum` = 0, and `overflow` is 1 because the carry chain leaves the word.
- R7: If the exact sum has no WIDTH-digit representation, `overflow` is 1. Any carry bit shifted past bit WIDTH−1 sets `overflow`.
- R8: Count the edge that accepts `start` as edge 0. Then `done` is 1 after an edge no later than floor((WIDTH−1)/2)+2, and `busy` and `done` are never 1 together. While `done` is 1 and no start arrives, `done`, `sum` and `overflow` hold their values.
- R9: Accepting a new `start` clears `done` and `overflow` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new addition; accepted when not busy |
| op_a | input | WIDTH (32) | First addend, radix −1+j, bit k has weight (−1+j)^k |
| op_b | input | WIDTH (32) | Second addend, same encoding |
| busy | output | 1 | Carry rounds in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| sum | output | WIDTH (32) | Sum in radix −1+j, truncated to WIDTH digits |
| overflow | output | 1 | At least one carry bit left the word |

## Verification
A six-digit instance is given every one of its 4096 operand pairs. Each result is compared with a reference that turns both operands into real/imaginary integer pairs, adds them, and extracts digits again by repeated division by −1+j. Pairs with no common ones show whether the carry path does anything when it should not. Pairs whose exact sum needs more than six digits show whether discarded carries raise the flag, and the worst-case pairs bound the round count. A 32-bit instance runs the single-carry case, the zero-rule case, a disjoint-operand case, a start request during a run, and a few mixed pairs against the same reference.

// File: rtl/cbin_pkg.sv
package cbin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } cbin_state_e;

  // Parity of three digits in one column.
  function automatic logic col_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // Two or more ones in a column emit a carry pair (columns +2 and +3).
  function automatic logic col_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/cbin_csa.sv
module cbin_csa #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] in_p,
  input  logic [WIDTH-1:0] in_q,
  input  logic [WIDTH-1:0] in_r,
  output logic [WIDTH-1:0] part_sum,
  output logic [WIDTH-1:0] carry_vec
);
  import cbin_pkg::*;

  for (genvar k = 0; k < WIDTH; k++) begin : g_col
    assign part_sum[k]  = col_sum(in_p[k], in_q[k], in_r[k]);
    assign carry_vec[k] = col_carry(in_p[k], in_q[k], in_r[k]);
  end

endmodule

// File: rtl/cbin_route.sv
module cbin_route #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] carry_vec,
  output logic [WIDTH-1:0] near_add,
  output logic [WIDTH-1:0] far_add,
  output logic             spill
);
  localparam int NEAR_SH = 2;
  localparam int FAR_SH  = 3;

  assign near_add = carry_vec << NEAR_SH;
  assign far_add  = carry_vec << FAR_SH;
  // Bits that the wider shift pushes out cover those of the narrower one.
  assign spill    = |carry_vec[WIDTH-1:WIDTH-FAR_SH];

endmodule

// File: rtl/cbin_ctrl.sv
module cbin_ctrl #(
  parameter int CAP = 128,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          carry_zero,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic          cap_hit,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] rounds
);
  import cbin_pkg::*;

  cbin_state_e state_q;
  logic        last_round;

  assign busy       = (state_q == ST_RUN);
  assign done       = (state_q == ST_HOLD);
  assign load       = start && !busy;
  assign last_round = (rounds == CW'(CAP - 1));
  assign finish     = busy && (carry_zero || last_round);
  assign step       = busy && !finish;
  assign cap_hit    = busy && !carry_zero && last_round;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rounds  <= '0;
    end else if (load) begin
      state_q <= ST_RUN;
      rounds  <= '0;
    end else if (finish) begin
      state_q <= ST_HOLD;
    end else if (step) begin
      rounds  <= rounds + CW'(1);
    end
  end

endmodule

// File: rtl/cbin_adder.sv
module cbin_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] sum,
  output logic             overflow
);
  localparam int CAP = 4 * WIDTH;
  localparam int CW  = $clog2(CAP + 1);

  logic [WIDTH-1:0] acc_p, acc_q, acc_r;
  logic [WIDTH-1:0] part_sum, carry_vec, near_add, far_add;
  logic [WIDTH-1:0] sum_q;
  logic             ovf_q;
  logic             spill, carry_zero;
  logic             load, step, finish, cap_hit;
  logic [CW-1:0]    rounds;

  assign carry_zero = (carry_vec == '0);

  cbin_csa #(.WIDTH(WIDTH)) u_csa (
    .in_p(acc_p), .in_q(acc_q), .in_r(acc_r),
    .part_sum(part_sum), .carry_vec(carry_vec)
  );

  cbin_route #(.WIDTH(WIDTH)) u_route (
    .carry_vec(carry_vec), .near_add(near_add), .far_add(far_add), .spill(spill)
  );

  cbin_ctrl #(.CAP(CAP), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .carry_zero(carry_zero),
    .load(load), .step(step), .finish(finish), .cap_hit(cap_hit),
    .busy(busy), .done(done), .rounds(rounds)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_p <= '0;
      acc_q <= '0;
      acc_r <= '0;
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      acc_p <= op_a;
      acc_q <= op_b;
      acc_r <= '0;
      ovf_q <= 1'b0;
    end else if (step) begin
      acc_p <= part_sum;
      acc_q <= near_add;
      acc_r <= far_add;
      ovf_q <= ovf_q | spill;
    end else if (finish) begin
      sum_q <= part_sum;
      ovf_q <= ovf_q | spill | cap_hit;
    end
  end

  assign sum      = sum_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/cbin_adder_chk.sv
module cbin_adder_chk #(
  parameter int WIDTH = 32,
  parameter int CW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] sum,
  input logic             overflow,
  input logic             spill,
  input logic             step,
  input logic             carry_zero,
  input logic [CW-1:0]    rounds
);
  localparam int ROUND_LIMIT = (WIDTH - 1) / 2 + 1;

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !overflow);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(sum) && $stable(overflow));

  p_round_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(rounds) <= ROUND_LIMIT);

  p_spill_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && spill |=> overflow);

  p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && carry_zero |=> done && !busy);

endmodule

bind cbin_adder cbin_adder_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sum(sum), .overflow(overflow), .spill(spill), .step(step),
  .carry_zero(carry_zero), .rounds(rounds)
);

// File: tb/sim_cbin_adder.sv
module sim_cbin_adder;
  localparam int SW = 6;
  localparam int BW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          st0 = 1'b0, st1 = 1'b0;
  logic [SW-1:0] a0 = '0, b0 = '0;
  logic [BW-1:0] a1 = '0, b1 = '0;
  logic          bz0, dn0, ov0, bz1, dn1, ov1;
  logic [SW-1:0] s0;
  logic [BW-1:0] s1;

  cbin_adder #(.WIDTH(SW)) u0 (.clk(clk), .rst_n(rst_n), .start(st0), .op_a(a0), .op_b(b0),
    .busy(bz0), .done(dn0), .sum(s0), .overflow(ov0));
  cbin_adder #(.WIDTH(BW)) u1 (.clk(clk), .rst_n(rst_n), .start(st1), .op_a(a1), .op_b(b1),
    .busy(bz1), .done(dn1), .sum(s1), .overflow(ov1));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Value of a digit string: Horner with multiplication by (-1+j).
  task automatic to_pair(input logic [31:0] v, input int w, output longint re, output longint im);
    re = 0; im = 0;
    for (int k = w - 1; k >= 0; k--) begin
      longint nr, ni;
      nr = -re - im;
      ni = re - im;
      re = nr + longint'(v[k]);
      im = ni;
    end
  endtask

  // Digit extraction by repeated exact division by (-1+j).
  task automatic from_pair(input longint re_in, input longint im_in, input int w,
                           output logic [31:0] bits, output bit fits);
    longint re, im;
    re = re_in; im = im_in; bits = '0;
    for (int k = 0; k < w; k++) begin
      longint nr, ni;
      bit d;
      d = ((re + im) % 2) != 0;
      bits[k] = d;
      re = re - longint'(d);
      nr = (-re + im) / 2;
      ni = (-re - im) / 2;
      re = nr; im = ni;
    end
    fits = (re == 0) && (im == 0);
  endtask

  task automatic expect_sum(input logic [31:0] a, input logic [31:0] b, input int w,
                            output logic [31:0] bits, output bit fits);
    longint ar, ai, br, bi;
    to_pair(a, w, ar, ai);
    to_pair(b, w, br, bi);
    from_pair(ar + br, ai + bi, w, bits, fits);
  endtask

  // Drive one request, return edges from acceptance until done is seen.
  task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b, output int edges);
    int cnt;
    @(negedge clk); a0 = a; b0 = b; st0 = 1'b1;
    @(negedge clk); st0 = 1'b0; cnt = 1;
    while (!dn0 && cnt < 64) begin @(negedge clk); cnt++; end
    edges = cnt;
  endtask

  task automatic run_big(input logic [BW-1:0] a, input logic [BW-1:0] b, output int edges);
    int cnt;
    @(negedge clk); a1 = a; b1 = b; st1 = 1'b1;
    @(negedge clk); st1 = 1'b0; cnt = 1;
    while (!dn1 && cnt < 64) begin @(negedge clk); cnt++; end
    edges = cnt;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] ref_bits;
    bit          fits;
    int          edges;
    logic [SW-1:0] held;
    localparam int LIM_S = (SW - 1) / 2 + 2;
    localparam int LIM_B = (BW - 1) / 2 + 2;

    repeat (3) @(negedge clk);
    // R1: reset values
    check(!bz0 && !dn0 && !ov0 && s0 == '0, "R1", {bz0, dn0, ov0, 26'(s0)}, 32'h0);
    check(!bz1 && !dn1 && !ov1 && s1 == '0, "R1", s1, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: 1 + 1 = 1100
    run_big(32'h1, 32'h1, edges);
    check(s1 == 32'hC && !ov1, "R5", s1, 32'hC);

    // R6: zero rule, carries leave the word
    run_big(32'h3, 32'h7, edges);
    check(s1 == 32'h0, "R6 sum", s1, 32'h0);
    check(ov1 == 1'b1, "R6 overflow", 32'(ov1), 32'h1);

    // R9: new start clears done and overflow at the accepting edge
    @(negedge clk); a1 = 32'h1; b1 = 32'h2; st1 = 1'b1;
    @(negedge clk); st1 = 1'b0;
    check(!dn1 && !ov1, "R9", {30'h0, dn1, ov1}, 32'h0);
    while (!dn1) @(negedge clk);
    check(s1 == 32'h3, "R4 disjoint small", s1, 32'h3);

    // R4: disjoint wide operands
    run_big(32'hA5A5_0000, 32'h0000_5A5A, edges);
    check(s1 == 32'hA5A5_5A5A && !ov1, "R4", s1, 32'hA5A5_5A5A);

    // R3 / R8: mixed wide pairs against the reference
    begin
      logic [31:0] va [4];
      logic [31:0] vb [4];
      va[0] = 32'h0000_00FF; vb[0] = 32'h0000_00FF;
      va[1] = 32'h1234_5678; vb[1] = 32'h0FED_CBA9;
      va[2] = 32'hFFFF_FFFF; vb[2] = 32'h0000_0001;
      va[3] = 32'h0F0F_0F0F; vb[3] = 32'h0303_0303;
      for (int i = 0; i < 4; i++) begin
        run_big(va[i], vb[i], edges);
        expect_sum(va[i], vb[i], BW, ref_bits, fits);
        check(s1 == ref_bits, "R3 wide", s1, ref_bits);
        check(edges - 1 <= LIM_B, "R8 wide latency", 32'(edges - 1), 32'(LIM_B));
        if (!fits) check(ov1 == 1'b1, "R7 wide", 32'(ov1), 32'h1);
      end
    end

    // R2: start while busy is ignored (1+1 needs two rounds)
    @(negedge clk); a0 = 6'h01; b0 = 6'h01; st0 = 1'b1;
    @(negedge clk); a0 = 6'h2A; b0 = 6'h15; st0 = 1'b1;
    check(bz0 == 1'b1, "R2 busy", 32'(bz0), 32'h1);
    @(negedge clk); st0 = 1'b0;
    while (!dn0) @(negedge clk);
    check(s0 == 6'h0C, "R2 ignored start", 32'(s0), 32'hC);

    // R8: result held while idle
    held = s0;
    repeat (5) @(negedge clk);
    check(dn0 && s0 == held, "R8 hold", 32'(s0), 32'(held));

    // Exhaustive sweep of the six-digit instance
    for (int ia = 0; ia < (1 << SW); ia++) begin
      for (int ib = 0; ib < (1 << SW); ib++) begin
        logic [SW-1:0] xa, xb;
        xa = SW'(ia); xb = SW'(ib);
        run_small(xa, xb, edges);
        expect_sum(32'(xa), 32'(xb), SW, ref_bits, fits);
        check(32'(s0) == ref_bits, "R3", 32'(s0), ref_bits);
        check(edges - 1 <= LIM_S, "R8 latency", 32'(edges - 1), 32'(LIM_S));
        if (!fits) check(ov0 == 1'b1, "R7", 32'(ov0), 32'h1);
        if ((xa & xb) == '0)
          check(s0 == (xa | xb) && !ov0, "R4", {ov0, 31'(s0)}, 32'(xa | xb));
        if (ia == 3 && ib == 7)
          check(s0 == '0 && ov0, "R6 small", {ov0, 31'(s0)}, 32'h8000_0000);
      end
    end

    finish_run();
  end

endmodule